// File: doc/BRIEF.md
# e.MMC Boot Acknowledge Receiver

This block handles the host side of a boot read from an e.MMC device. A boot read does not begin when the block is idle and the device line moves. Software first selects the boot command kind. The next command-register write strobe then launches the sequence. From that point the block samples the DAT0 line once per card-clock enable tick.

When acknowledge checking is on, the block first waits for the device's handshake and checks it. It then waits for the start bit of the boot data and forwards a programmed number of data bits, one per tick, to a downstream consumer. Two failures are reported. A wrong handshake gives an acknowledge error. No start bit before a programmable tick limit gives a data timeout. Each failure has a sticky flag, gated by a status-enable bit and cleared by writing one. An interrupt line is driven by each flag ANDed with its interrupt-enable bit.

States: `ST_IDLE`, `ST_ACK_WAIT` (waiting for the handshake start bit), `ST_ACK_PAT` (three pattern bits), `ST_ACK_STOP` (end bit), `ST_DAT_WAIT` (waiting for the data start bit) and `ST_DAT_RUN` (delivering bits).

Transitions:
- IDLE to ACK_WAIT or DAT_WAIT on a boot launch, depending on whether acknowledge checking is on.
- ACK_WAIT to ACK_PAT on a low start bit.
- ACK_PAT to ACK_STOP after three matching bits.
- ACK_STOP to DAT_WAIT on a high end bit.
- DAT_WAIT to DAT_RUN on a low start bit.
- DAT_RUN to IDLE after the last bit.
- Either wait state to IDLE on timeout.
- ACK_PAT or ACK_STOP to IDLE on a mismatch.

Top module: `emmc_boot_ack_rx`

## Requirements
- R1: The command-kind field is 2 bits: 0 normal, 1 wait-for-interrupt, 2 stream, 3 boot. Only a `cmd_wr` strobe while idle with `cmd_kind` = 3 launches a boot. `busy` is high from the following cycle. Strobes carrying any other code leave the block idle.
- R2: With `ack_en` high, the block waits for a low start bit. It then expects the bits 0, 1, 0 in that order, then a high end bit, all on DAT0, before it waits for the data start bit. No `data_valid` is produced during this phase.
- R3: Any handshake bit that differs from the expected value ends the boot (back to idle). It sets flag bit 0 (acknowledge error) in `err_flags` only if `stat_en[0]` is high.
- R4: In either start-bit wait state, `timeout_lim` consecutive high ticks end the boot. This sets flag bit 1 (data timeout) in `err_flags` only if `stat_en[1]` is high. The tick count restarts on entry to each wait state, and a low bit stops it.
- R5: With `ack_en` low, a launch goes straight to waiting for the data start bit.
- R6: After the data start bit, each of the next `data_bits` ticks raises `data_valid` in that tick's cycle, with `data_bit` equal to DAT0. After the last bit the block returns to idle.
- R7: Flags are zero after reset and stay set until a one is written to the matching `clr_w1c` bit.
- R8: `irq` is high exactly when some flag is set and its bit in `irq_en` is high.
- R9: `cmd_wr` strobes while a boot is in progress have no effect on the sequence.
- R10: DAT0 is ignored in cycles without `tick`: no state advance, no data and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_en | input | 1 | Enable handshake check |
| cmd_kind | input | 2 | Command kind code (3 = boot) |
| cmd_wr | input | 1 | Command-register write strobe |
| tick | input | 1 | Card-clock enable, DAT0 sampling point |
| dat0 | input | 1 | Device data line 0 |
| timeout_lim | input | TMO_W | Start-bit wait limit in ticks |
| data_bits | input | LEN_W | Number of boot data bits to forward |
| stat_en | input | 2 | Status enables: bit 0 ack error, bit 1 timeout |
| irq_en | input | 2 | Interrupt enables, same bit order |
| clr_w1c | input | 2 | Write-one-to-clear for the flags |
| busy | output | 1 | Boot sequence in progress |
| data_valid | output | 1 | Boot data bit present |
| data_bit | output | 1 | Boot data bit value |
| err_flags | output | 2 | Sticky flags: bit 0 ack error, bit 1 timeout |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state register shows up at the ports within one tick. Stray `data_valid` pulses appear during the handshake, or `busy` drops early, or an error flag rises on a correct pattern at the first tick the bad state decodes. A wrong tick or bit counter shows as a timeout one tick early or late, or as a data burst of the wrong length. Both are visible on the tick that ends the phase. The directed scenarios therefore check state at the ticks just before and just after each boundary.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_WAIT,
        ST_ACK_PAT,
        ST_ACK_STOP,
        ST_DAT_WAIT,
        ST_DAT_RUN
    } boot_st_e;

    localparam logic [1:0] CMD_KIND_BOOT = 2'd3;
    localparam logic [2:0] ACK_CODE      = 3'b010;
    localparam int         ACK_LEN       = 3;
    localparam int         NUM_FLAGS     = 2;
    localparam int         FLG_ACK       = 0;
    localparam int         FLG_TMO       = 1;

endpackage

// File: rtl/emmc_boot_cnt.sv
module emmc_boot_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/emmc_boot_flags.sv
module emmc_boot_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] ev,
    input  logic [NF-1:0] stat_en,
    input  logic [NF-1:0] irq_en,
    input  logic [NF-1:0] clr_w1c,
    output logic [NF-1:0] flags,
    output logic          irq
);

    logic [NF-1:0] masked;

    for (genvar g = 0; g < NF; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (ev[g] && stat_en[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_w1c[g]) begin
                flags[g] <= 1'b0;
            end
        end
        assign masked[g] = flags[g] & irq_en[g];
    end

    assign irq = |masked;

endmodule

// File: rtl/emmc_boot_fsm.sv
module emmc_boot_fsm
    import emmc_boot_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int LEN_W = 8,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_en,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_wr,
    input  logic             tick,
    input  logic             dat0,
    input  logic [TMO_W-1:0] timeout_lim,
    input  logic [LEN_W-1:0] data_bits,
    input  logic [CW-1:0]    cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             ev_ack,
    output logic             ev_tmo,
    output logic             busy,
    output logic             data_valid,
    output logic             data_bit
);

    localparam int XW = CW + 1;

    boot_st_e   state, state_nxt;
    logic [1:0] idx, idx_nxt;
    logic [XW-1:0] cnt_p1;
    logic [XW-1:0] lim_x;
    logic [XW-1:0] len_x;
    logic          tmo_hit;
    logic          len_hit;
    logic          exp_bit;

    assign cnt_p1  = {1'b0, cnt} + 1'b1;
    assign lim_x   = XW'(timeout_lim);
    assign len_x   = XW'(data_bits);
    assign tmo_hit = (cnt_p1 >= lim_x);
    assign len_hit = (cnt_p1 >= len_x);
    assign exp_bit = ACK_CODE[ACK_LEN - 1 - int'(idx)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        ev_ack    = 1'b0;
        ev_tmo    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr && (cmd_kind == CMD_KIND_BOOT)) begin
                    state_nxt = ack_en ? ST_ACK_WAIT : ST_DAT_WAIT;
                    cnt_clr   = 1'b1;
                end
            end
            ST_ACK_WAIT: begin
                if (tick) begin
                    if (!dat0) begin
                        state_nxt = ST_ACK_PAT;
                        idx_nxt   = '0;
                        cnt_clr   = 1'b1;
                    end else if (tmo_hit) begin
                        state_nxt = ST_IDLE;
                        ev_tmo    = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_ACK_PAT: begin
                if (tick) begin
                    if (dat0 != exp_bit) begin
                        state_nxt = ST_IDLE;
                        ev_ack    = 1'b1;
                    end else if (int'(idx) == ACK_LEN - 1) begin
                        state_nxt = ST_ACK_STOP;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            ST_ACK_STOP: begin
                if (tick) begin
                    if (dat0) begin
                        state_nxt = ST_DAT_WAIT;
                        cnt_clr   = 1'b1;
                    end else begin
                        state_nxt = ST_IDLE;
                        ev_ack    = 1'b1;
                    end
                end
            end
            ST_DAT_WAIT: begin
                if (tick) begin
                    if (!dat0) begin
                        state_nxt = ST_DAT_RUN;
                        cnt_clr   = 1'b1;
                    end else if (tmo_hit) begin
                        state_nxt = ST_IDLE;
                        ev_tmo    = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_DAT_RUN: begin
                if (tick) begin
                    if (len_hit) begin
                        state_nxt = ST_IDLE;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        data_valid = (state == ST_DAT_RUN) && tick;
        data_bit   = data_valid & dat0;
    end

endmodule

// File: rtl/emmc_boot_ack_rx.sv
module emmc_boot_ack_rx
    import emmc_boot_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_en,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_wr,
    input  logic             tick,
    input  logic             dat0,
    input  logic [TMO_W-1:0] timeout_lim,
    input  logic [LEN_W-1:0] data_bits,
    input  logic [1:0]       stat_en,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       clr_w1c,
    output logic             busy,
    output logic             data_valid,
    output logic             data_bit,
    output logic [1:0]       err_flags,
    output logic             irq
);

    localparam int CW = (TMO_W > LEN_W) ? TMO_W : LEN_W;

    logic          cnt_clr;
    logic          cnt_inc;
    logic [CW-1:0] cnt;
    logic          ev_ack;
    logic          ev_tmo;
    logic [NUM_FLAGS-1:0] ev_vec;

    emmc_boot_cnt #(.CW(CW)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    emmc_boot_fsm #(.TMO_W(TMO_W), .LEN_W(LEN_W), .CW(CW)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_en      (ack_en),
        .cmd_kind    (cmd_kind),
        .cmd_wr      (cmd_wr),
        .tick        (tick),
        .dat0        (dat0),
        .timeout_lim (timeout_lim),
        .data_bits   (data_bits),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .ev_ack      (ev_ack),
        .ev_tmo      (ev_tmo),
        .busy        (busy),
        .data_valid  (data_valid),
        .data_bit    (data_bit)
    );

    always_comb begin
        ev_vec          = '0;
        ev_vec[FLG_ACK] = ev_ack;
        ev_vec[FLG_TMO] = ev_tmo;
    end

    emmc_boot_flags #(.NF(NUM_FLAGS)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_vec),
        .stat_en (stat_en),
        .irq_en  (irq_en),
        .clr_w1c (clr_w1c),
        .flags   (err_flags),
        .irq     (irq)
    );

endmodule

// File: rtl/emmc_boot_ack_chk.sv
module emmc_boot_ack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_kind,
    input logic       cmd_wr,
    input logic       tick,
    input logic [1:0] stat_en,
    input logic [1:0] irq_en,
    input logic [1:0] clr_w1c,
    input logic       busy,
    input logic       data_valid,
    input logic [1:0] err_flags,
    input logic       irq
);

    AST_START_NEEDS_BOOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_wr && cmd_kind == 2'd3)) |=> !busy); // R1

    AST_ACK_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[0]) |-> ($past(stat_en[0]) && !busy)); // R3

    AST_TMO_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[1]) |-> ($past(stat_en[1]) && !busy)); // R4

    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> busy); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[0] && !clr_w1c[0]) |=> err_flags[0]); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq); // R8

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy); // R10

    AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> tick); // R10

endmodule

bind emmc_boot_ack_rx emmc_boot_ack_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_kind   (cmd_kind),
    .cmd_wr     (cmd_wr),
    .tick       (tick),
    .stat_en    (stat_en),
    .irq_en     (irq_en),
    .clr_w1c    (clr_w1c),
    .busy       (busy),
    .data_valid (data_valid),
    .err_flags  (err_flags),
    .irq        (irq)
);

// File: tb/emmc_boot_ack_rx_tb.sv
module emmc_boot_ack_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TMO_W = 16;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ack_en = 1'b1;
    logic [1:0]       cmd_kind = 2'd0;
    logic             cmd_wr = 1'b0;
    logic             tick = 1'b0;
    logic             dat0 = 1'b1;
    logic [TMO_W-1:0] timeout_lim = 16'd8;
    logic [LEN_W-1:0] data_bits = 8'd4;
    logic [1:0]       stat_en = 2'b11;
    logic [1:0]       irq_en = 2'b11;
    logic [1:0]       clr_w1c = 2'b00;
    logic             busy;
    logic             data_valid;
    logic             data_bit;
    logic [1:0]       err_flags;
    logic             irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rx_val;
    int          rx_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    emmc_boot_ack_rx #(.TMO_W(TMO_W), .LEN_W(LEN_W)) dut_i (
        .clk (clk), .rst_n (rst_n), .ack_en (ack_en), .cmd_kind (cmd_kind),
        .cmd_wr (cmd_wr), .tick (tick), .dat0 (dat0),
        .timeout_lim (timeout_lim), .data_bits (data_bits),
        .stat_en (stat_en), .irq_en (irq_en), .clr_w1c (clr_w1c),
        .busy (busy), .data_valid (data_valid), .data_bit (data_bit),
        .err_flags (err_flags), .irq (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_bit(input logic b);
        @(negedge clk);
        dat0 = b;
        tick = 1'b1;
        #1;
        if (data_valid) begin
            rx_val = {rx_val[30:0], data_bit};
            rx_cnt++;
        end
        @(negedge clk);
        tick = 1'b0;
        dat0 = 1'b1;
    endtask

    task automatic launch(input logic [1:0] kind);
        @(negedge clk);
        cmd_kind = kind;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
        cmd_kind = 2'd0;
        rx_val   = '0;
        rx_cnt   = 0;
    endtask

    task automatic clear_flags(input logic [1:0] m);
        @(negedge clk);
        clr_w1c = m;
        @(negedge clk);
        clr_w1c = 2'b00;
    endtask

    task automatic t_reset();
        check("R7 reset flags", err_flags, 2'b00);
        check("R7 reset busy", busy, 1'b0);
        check("R8 reset irq", irq, 1'b0);
        check("R6 reset valid", data_valid, 1'b0);
    endtask

    task automatic t_good_ack();
        ack_en = 1'b1; data_bits = 8'd4; timeout_lim = 16'd8;
        launch(2'd3);
        check("R1 busy after boot write", busy, 1'b1);
        tick_bit(1); tick_bit(1);
        tick_bit(0); tick_bit(0); tick_bit(1); tick_bit(0); tick_bit(1);
        check("R2 no data during ack", rx_cnt, 0);
        check("R2 busy after ack", busy, 1'b1);
        check("R2 no flags on good ack", err_flags, 2'b00);
        tick_bit(0);
        tick_bit(1); tick_bit(0); tick_bit(1); tick_bit(1);
        check("R6 data count", rx_cnt, 4);
        check("R6 data value", rx_val, 32'hB);
        check("R6 idle after data", busy, 1'b0);
    endtask

    task automatic t_bad_pattern();
        ack_en = 1'b1;
        launch(2'd3);
        tick_bit(0); tick_bit(0); tick_bit(0);
        check("R3 ack error flag", err_flags, 2'b01);
        check("R3 idle after ack error", busy, 1'b0);
        check("R8 irq on ack error", irq, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 flag sticky", err_flags, 2'b01);
        clear_flags(2'b01);
        check("R7 flag cleared", err_flags, 2'b00);
        check("R8 irq cleared", irq, 1'b0);
    endtask

    task automatic t_bad_end();
        launch(2'd3);
        tick_bit(0); tick_bit(0); tick_bit(1); tick_bit(0);
        check("R3 busy before end bit", busy, 1'b1);
        tick_bit(0);
        check("R3 end bit error", err_flags, 2'b01);
        check("R3 no data after bad end", rx_cnt, 0);
        clear_flags(2'b01);
    endtask

    task automatic t_timeout();
        timeout_lim = 16'd4;
        launch(2'd3);
        tick_bit(1); tick_bit(1); tick_bit(1);
        check("R4 busy before limit", busy, 1'b1);
        check("R4 no flag before limit", err_flags, 2'b00);
        tick_bit(1);
        check("R4 timeout flag", err_flags, 2'b10);
        check("R4 idle after timeout", busy, 1'b0);
        clear_flags(2'b10);
        ack_en = 1'b0;
        launch(2'd3);
        tick_bit(1); tick_bit(1); tick_bit(1); tick_bit(0);
        check("R4 start bit before limit", err_flags, 2'b00);
        check("R4 data phase reached", busy, 1'b1);
        tick_bit(1); tick_bit(1); tick_bit(1); tick_bit(1);
        check("R4 data ends cleanly", busy, 1'b0);
        ack_en = 1'b1;
        timeout_lim = 16'd8;
    endtask

    task automatic t_gating();
        stat_en = 2'b10;
        launch(2'd3);
        tick_bit(0); tick_bit(1);
        check("R3 gated ack flag", err_flags, 2'b00);
        check("R3 gated idle", busy, 1'b0);
        stat_en = 2'b11; irq_en = 2'b00; timeout_lim = 16'd2;
        launch(2'd3);
        tick_bit(1); tick_bit(1);
        check("R4 timeout with irq masked", err_flags, 2'b10);
        check("R8 irq masked", irq, 1'b0);
        @(negedge clk);
        irq_en = 2'b10;
        #1;
        check("R8 irq unmasked", irq, 1'b1);
        clear_flags(2'b11);
        irq_en = 2'b11; timeout_lim = 16'd8;
    endtask

    task automatic t_no_ack();
        ack_en = 1'b0; data_bits = 8'd3;
        launch(2'd3);
        tick_bit(0);
        tick_bit(0); tick_bit(1); tick_bit(1);
        check("R5 data count without ack", rx_cnt, 3);
        check("R5 data value without ack", rx_val, 32'h3);
        check("R5 idle", busy, 1'b0);
        ack_en = 1'b1;
    endtask

    task automatic t_ignore();
        launch(2'd0);
        check("R1 normal kind ignored", busy, 1'b0);
        launch(2'd1);
        check("R1 wait-irq kind ignored", busy, 1'b0);
        launch(2'd2);
        check("R1 stream kind ignored", busy, 1'b0);
        ack_en = 1'b0; data_bits = 8'd2;
        launch(2'd3);
        @(negedge clk);
        dat0 = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 no advance without tick", rx_cnt, 0);
        check("R10 busy without tick", busy, 1'b1);
        dat0 = 1'b1;
        launch(2'd3);
        check("R9 write during boot", busy, 1'b1);
        tick_bit(0);
        tick_bit(1); tick_bit(0);
        check("R9 data after ignored write", rx_val, 32'h2);
        check("R9 count after ignored write", rx_cnt, 2);
        check("R9 idle", busy, 1'b0);
        ack_en = 1'b1;
    endtask

    initial begin
        rx_val = '0;
        rx_cnt = 0;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_good_ack();
        t_bad_pattern();
        t_bad_end();
        t_timeout();
        t_gating();
        t_no_ack();
        t_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule